// File: doc/BRIEF.md
# Reload Down-Counter Timer

A general-purpose peripheral timer built around a down counter of parameterised width (16 bits by default). Software loads a reload value, chooses a count clock from an internal prescaler and starts the timer with a software trigger. One peripheral clock after the trigger the reload value is copied into the counter. The counter then steps down once per prescaler tick. When it steps below zero it underflows. In reload mode it then reloads and keeps running. In one-shot mode it parks at all ones and stops.

Every underflow sets an interrupt request flag. That flag is gated by an interrupt enable onto the interrupt line. A timer output toggles on each underflow in reload mode, and is asserted for the whole run in one-shot mode. An output-level bit inverts its polarity. The collisions between bus writes and timer events follow fixed priority rules, so software never sees an ambiguous outcome.

The register interface has a write port and a combinational read port, each with a 2-bit word address. Address 0 is control/status, address 1 is the reload value, and address 2 is the current count (read only). Address 3 reads zero.

The control word uses these bits. Bit 0 is run (count enable). Bit 1 is trigger: writing 1 starts a run, and the bit always reads 0. Bit 2 is the request flag: writing 0 clears it and writing 1 has no effect. Bit 3 is interrupt enable. Bit 4 is reload enable. Bit 5 is output level. Bits 8:6 are the clock select. Bits 11:9 are the mode, whose bit 11 must be 0.

Top module: `rtim_top`

## Requirements
- R1: Clock-select codes 3'b100 and 3'b111 are reserved. While either is selected the counter holds its value, although a trigger still loads it.
- R2: When mode bit 11 is 1 the counter never decrements, although a trigger still loads it.
- R3: A write of the control word with bit 1 and bit 0 both set loads the reload value into the counter at the next clock edge after the write edge.
- R4: An underflow sets the request flag (control bit 2). If a write of 0 to bit 2 falls in the same cycle as an underflow, the flag stays set. At any other cycle that write clears the flag. The irq output is the flag ANDed with interrupt enable (bit 3).
- R5: A reload-register write in the same cycle as an underflow reload puts the old value in the counter. The new value is used at the next reload.
- R6: A trigger load that falls in the same cycle as a prescaler tick wins, and the decrement is dropped. After a load the count holds for one full prescaler period.
- R7: Setting run and trigger in one write starts a run. A trigger written with bit 0 = 0 is ignored, and the count does not change.
- R8: Writes to clock select, mode, output level, reload enable and interrupt enable (bits 11:3 except bit 2) are ignored while run is 1 before the write.
- R9: The clock-select codes 000, 001, 010, 011, 101 and 110 divide the clock by 2, 8, 32, 64, 128 and 128. A run started at write edge E0 with reload value R underflows at edge E0 + 1 + div*(R+1).
- R10: At underflow in reload mode, the counter reloads and timerOut toggles. In one-shot mode the counter becomes 16'hFFFF, the run ends and timerOut returns to idle.
- R11: timerOut equals the output-level bit while idle and at the start of a reload-mode run. It is the inverse of that bit during a one-shot run.
- R12: Writing run = 0 stops counting from the next cycle and holds the current count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write word address |
| wrData | input | 16 | Write data |
| rdAddr | input | 2 | Read word address |
| rdData | output | 16 | Read data for rdAddr (combinational) |
| timerOut | output | 1 | Timer output |
| irq | output | 1 | Interrupt request |

## Verification
The bench uses the default parameters: a 16-bit counter and a 7-bit prescaler. With these every divider code up to divide-by-128 is reachable, and small reload values keep each run within a few hundred cycles. A vector table times the first underflow for every legal clock code in both modes. Directed cases then place bus writes on the exact underflow and load edges, to exercise the flag, reload-register and decrement collision rules.

// File: rtl/rtim_pkg.sv
package rtim_pkg;
  localparam int CTRL_W  = 12;
  localparam int B_RUN   = 0;
  localparam int B_TRG   = 1;
  localparam int B_FLAG  = 2;
  localparam int B_IE    = 3;
  localparam int B_RLD   = 4;
  localparam int B_OUTL  = 5;
  localparam int B_SEL   = 6;
  localparam int B_MODE  = 9;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_RELOAD = 2'd1;
  localparam logic [1:0] A_COUNT = 2'd2;

  typedef struct packed {
    logic load;
    logic dec;
    logic park;
  } rtim_strb_t;

  function automatic logic [2:0] divShift(input logic [2:0] sel);
    case (sel)
      3'b000: return 3'd1;
      3'b001: return 3'd3;
      3'b010: return 3'd5;
      3'b011: return 3'd6;
      3'b101, 3'b110: return 3'd7;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic selValid(input logic [2:0] sel);
    return !(sel == 3'b100 || sel == 3'b111);
  endfunction
endpackage

// File: rtl/rtim_ctrl.sv
module rtim_ctrl
  import rtim_pkg::*;
#(
  parameter int PRE_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [CTRL_W-1:0] wrCtrl,
  input  logic              cntZero,
  output rtim_strb_t        strb,
  output logic [CTRL_W-1:0] ctrlWord,
  output logic              timerOut,
  output logic              irq
);
  logic runEn, intEn, rldEn, outLvl, flag, active, loadPend, tState;
  logic [2:0] clkSel, mode;
  logic [PRE_W-1:0] presc, divMask;
  logic ctrlWr, trigValid, selOk, modeOk, running, tickNow, uflow;

  assign ctrlWr    = wrEn && (wrAddr == A_CTRL);
  assign trigValid = ctrlWr && wrCtrl[B_TRG] && wrCtrl[B_RUN];
  assign selOk     = selValid(clkSel);
  assign modeOk    = !mode[2];
  assign running   = runEn && active && selOk && modeOk && !loadPend;

  always_comb begin
    divMask = (PRE_W'(1) << divShift(clkSel)) - PRE_W'(1);
  end

  assign tickNow = running && (presc == divMask);
  assign uflow   = tickNow && cntZero;

  always_comb begin
    strb.load = loadPend || (uflow && rldEn);
    strb.dec  = tickNow && !cntZero;
    strb.park = uflow && !rldEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runEn <= 1'b0; intEn <= 1'b0; rldEn <= 1'b0; outLvl <= 1'b0;
      clkSel <= 3'b000; mode <= 3'b000;
    end else if (ctrlWr) begin
      runEn <= wrCtrl[B_RUN];
      if (!runEn) begin
        intEn  <= wrCtrl[B_IE];
        rldEn  <= wrCtrl[B_RLD];
        outLvl <= wrCtrl[B_OUTL];
        clkSel <= wrCtrl[B_SEL +: 3];
        mode   <= wrCtrl[B_MODE +: 3];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadPend <= 1'b0;
      active   <= 1'b0;
      presc    <= '0;
      tState   <= 1'b0;
      flag     <= 1'b0;
    end else begin
      loadPend <= trigValid;
      if (loadPend) begin
        active <= 1'b1;
        presc  <= '0;
        tState <= !rldEn;
      end else begin
        if (running) presc <= (presc == divMask) ? '0 : presc + PRE_W'(1);
        if (uflow) begin
          tState <= rldEn ? ~tState : 1'b0;
          if (!rldEn) active <= 1'b0;
        end
      end
      if (uflow) flag <= 1'b1;
      else if (ctrlWr && !wrCtrl[B_FLAG]) flag <= 1'b0;
    end
  end

  assign timerOut = tState ^ outLvl;
  assign irq      = flag & intEn;
  assign ctrlWord = {mode, clkSel, outLvl, rldEn, intEn, flag, 1'b0, runEn};

  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    uflow |=> flag);
  a_r4_irq_gate: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> flag);
  a_r1_reserved_hold: assert property (@(posedge clk) disable iff (!rstN)
    !selOk |-> !strb.dec);
  a_r2_mode_hold: assert property (@(posedge clk) disable iff (!rstN)
    mode[2] |-> !strb.dec);
  a_r12_stop_hold: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |-> !(strb.dec || strb.park));
endmodule

// File: rtl/rtim_datapath.sv
module rtim_datapath
  import rtim_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [DW-1:0]     wrData,
  input  logic [1:0]        rdAddr,
  input  logic [CTRL_W-1:0] ctrlWord,
  input  rtim_strb_t        strb,
  output logic              cntZero,
  output logic [DW-1:0]     rdData
);
  logic [DW-1:0] rldReg, cnt;

  always_ff @(posedge clk) begin
    if (!rstN) rldReg <= '0;
    else if (wrEn && wrAddr == A_RELOAD) rldReg <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) cnt <= '0;
    else if (strb.load) cnt <= rldReg;
    else if (strb.park) cnt <= '1;
    else if (strb.dec) cnt <= cnt - DW'(1);
  end

  assign cntZero = (cnt == '0);

  always_comb begin
    case (rdAddr)
      A_CTRL:   rdData = {{(DW-CTRL_W){1'b0}}, ctrlWord};
      A_RELOAD: rdData = rldReg;
      A_COUNT:  rdData = cnt;
      default:  rdData = '0;
    endcase
  end

  a_r3_load_value: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> cnt == $past(rldReg));
  a_r10_park_ones: assert property (@(posedge clk) disable iff (!rstN)
    strb.park |=> cnt == '1);
  a_r9_single_step: assert property (@(posedge clk) disable iff (!rstN)
    strb.dec |=> cnt == $past(cnt) - DW'(1));
  a_r6_one_action: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |-> $onehot0({strb.load, strb.dec, strb.park}));
endmodule

// File: rtl/rtim_top.sv
module rtim_top
  import rtim_pkg::*;
#(
  parameter int DW    = 16,
  parameter int PRE_W = 7
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [1:0]    wrAddr,
  input  logic [DW-1:0] wrData,
  input  logic [1:0]    rdAddr,
  output logic [DW-1:0] rdData,
  output logic          timerOut,
  output logic          irq
);
  rtim_strb_t        strb;
  logic [CTRL_W-1:0] ctrlWord;
  logic              cntZero;

  rtim_ctrl #(.PRE_W(PRE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrCtrl(wrData[CTRL_W-1:0]), .cntZero(cntZero), .strb(strb),
    .ctrlWord(ctrlWord), .timerOut(timerOut), .irq(irq)
  );

  rtim_datapath #(.DW(DW)) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .ctrlWord(ctrlWord), .strb(strb), .cntZero(cntZero),
    .rdData(rdData)
  );
endmodule

// File: tb/tb_rtim_top.sv
`timescale 1ns/1ps
module tb_rtim_top;
  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0;
  logic [1:0] wrAddr = '0, rdAddr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic timerOut, irq;
  int nChecks = 0, nFail = 0;

  always #2 clk = ~clk;

  rtim_top dut (.clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData),
    .timerOut(timerOut), .irq(irq));

  // {sel[2:0], reload[15:0], reloadEn, outLevel, expected edges to underflow[9:0]}
  localparam logic [30:0] VEC [6] = '{
    {3'b000, 16'd5, 1'b1, 1'b0, 10'd13},
    {3'b001, 16'd3, 1'b0, 1'b1, 10'd33},
    {3'b010, 16'd2, 1'b1, 1'b1, 10'd97},
    {3'b011, 16'd1, 1'b0, 1'b0, 10'd129},
    {3'b101, 16'd0, 1'b1, 1'b0, 10'd129},
    {3'b110, 16'd2, 1'b0, 1'b1, 10'd385}
  };

  function automatic logic [15:0] mk(input logic [2:0] sel, input logic [2:0] md,
      input logic ol, input logic rl, input logic ie, input logic trg,
      input logic run, input logic fl);
    return {4'b0, md, sel, ol, rl, ie, fl, trg, run};
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    rdAddr = a; #0.5; d = rdData;
  endtask

  task automatic stopT();
    wr(2'd0, 16'h0000);
  endtask

  logic [15:0] v, c1;
  bit done = 0;

  initial begin
    #800000;
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state
    rd(2'd0, v); chk(v == 16'h0, "R4 reset ctrl", v, 0);
    rd(2'd2, v); chk(v == 16'h0, "R12 reset count", v, 0);
    chk(timerOut == 1'b0, "R11 reset out", timerOut, 0);
    chk(irq == 1'b0, "R4 reset irq", irq, 0);

    // vector table: one run per legal clock code
    foreach (VEC[i]) begin
      logic [2:0] sel; logic [15:0] rv; logic rl, ol; int expN, n;
      {sel, rv, rl, ol} = VEC[i][30:10];
      expN = int'(VEC[i][9:0]);
      stopT();
      wr(2'd1, rv);
      wr(2'd0, mk(sel, 3'b000, ol, rl, 1'b1, 1'b1, 1'b1, 1'b0));
      n = 0;
      forever begin
        @(posedge clk); n++;
        @(negedge clk);
        if (n == 1) begin
          rd(2'd2, v); chk(v == rv, "R3 load next edge", v, rv);
          chk(timerOut == (rl ? ol : ~ol), "R11 run level", timerOut, rl ? ol : ~ol);
        end
        if (irq || n > 1000) break;
      end
      chk(n == expN, "R9 underflow edge", n, expN);
      chk(irq == 1'b1, "R7 run started irq", irq, 1);
      rd(2'd2, v);
      chk(v == (rl ? rv : 16'hFFFF), "R10 count after underflow", v, rl ? rv : 16'hFFFF);
      chk(timerOut == (rl ? ~ol : ol), "R10 out after underflow", timerOut, rl ? ~ol : ol);
    end

    // R8: protected fields ignored while running
    stopT(); wr(2'd1, 16'd100);
    wr(2'd0, mk(3'b000, 3'b000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0));
    wr(2'd0, mk(3'b100, 3'b100, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1));
    rd(2'd0, v); chk(v == 16'h0019, "R8 ctrl unchanged", v, 16'h0019);
    chk(timerOut == 1'b0, "R8 out level unchanged", timerOut, 0);

    // R12: clearing run holds count; R7: trigger without run ignored
    wr(2'd0, mk(3'b000, 3'b000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1));
    rd(2'd2, c1);
    repeat (10) @(negedge clk);
    rd(2'd2, v); chk(v == c1, "R12 count held", v, c1);
    wr(2'd0, mk(3'b000, 3'b000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1));
    repeat (3) @(negedge clk);
    rd(2'd2, v); chk(v == c1, "R7 trigger ignored", v, c1);

    // R1: reserved clock codes
    stopT(); wr(2'd1, 16'd20);
    wr(2'd0, mk(3'b100, 3'b000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0));
    repeat (40) @(negedge clk);
    rd(2'd2, v); chk(v == 16'd20, "R1 code 100 holds", v, 20);
    stopT(); wr(2'd1, 16'd21);
    wr(2'd0, mk(3'b111, 3'b000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0));
    repeat (40) @(negedge clk);
    rd(2'd2, v); chk(v == 16'd21, "R1 code 111 holds", v, 21);

    // R2: mode top bit set
    stopT(); wr(2'd1, 16'd22);
    wr(2'd0, mk(3'b000, 3'b100, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0));
    repeat (40) @(negedge clk);
    rd(2'd2, v); chk(v == 16'd22, "R2 mode holds", v, 22);

    // R4: flag set beats clear in the underflow cycle (div2, R=1 -> edge E0+5)
    stopT(); wr(2'd1, 16'd1);
    wr(2'd0, mk(3'b000, 3'b000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0));
    repeat (4) @(negedge clk);
    wrEn = 1'b1; wrAddr = 2'd0; wrData = mk(3'b000, 3'b000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    @(negedge clk); wrEn = 1'b0;
    chk(irq == 1'b1, "R4 set beats clear", irq, 1);
    wr(2'd0, mk(3'b000, 3'b000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0));
    chk(irq == 1'b0, "R4 clear later", irq, 0);

    // R5: reload write in the reload cycle
    stopT(); wr(2'd1, 16'd1);
    wr(2'd0, mk(3'b000, 3'b000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0));
    repeat (4) @(negedge clk);
    wrEn = 1'b1; wrAddr = 2'd1; wrData = 16'd9;
    @(negedge clk); wrEn = 1'b0;
    rd(2'd2, v); chk(v == 16'd1, "R5 old value loaded", v, 1);
    repeat (4) @(negedge clk);
    rd(2'd2, v); chk(v == 16'd9, "R5 new value next reload", v, 9);

    // R6: retrigger at two prescaler phases, load wins over tick
    for (int k = 5; k <= 6; k++) begin
      stopT(); wr(2'd1, 16'd50);
      wr(2'd0, mk(3'b000, 3'b000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0));
      repeat (k) @(negedge clk);
      wr(2'd0, mk(3'b000, 3'b000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0));
      @(negedge clk); rd(2'd2, v); chk(v == 16'd50, "R6 load wins", v, 50);
      @(negedge clk); rd(2'd2, v); chk(v == 16'd50, "R6 hold one period", v, 50);
      @(negedge clk); rd(2'd2, v); chk(v == 16'd49, "R6 first step", v, 49);
    end

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule